// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block is the feedback counter of a fractional-N frequency synthesizer. It divides a fast input clock by a programmed base modulus and emits one single-cycle pulse per output period. In fractional mode an external modulator supplies a small signed offset for each output period, so that the instantaneous modulus moves around the programmed average while the average itself stays exact.

An optional fixed divide-by-two stage can sit in front of the counter. It makes the counter advance only on every second input clock, which doubles every period and allows faster input clocks. The base modulus, the offset and the mode are all taken only when the counter reloads, at a period boundary, so changing them never shortens or stretches the period already in progress. A base outside the legal window for the current mode is pulled to the nearest legal bound, and a sticky flag records that this happened. The divided pulse can also be copied to a test tap by a 5-bit test-select code.

Top module: `fbdiv_top`

## Requirements
- R1: While `rst_n` is low, `div_pulse`, `test_tap` and `range_err` are all 0.
- R2: In integer mode (`frac_en` = 0, prescaler off), `div_pulse` rises once every N input clocks, where N is the base modulus, legal from 16 to 524287, and each pulse is exactly one input clock wide.
- R3: In fractional mode (`frac_en` = 1), the period is base + offset input clocks; `offset` is a 4-bit two's-complement value, taken at the clock edge on which `div_pulse` rises, and it governs the period that begins with that pulse.
- R4: In fractional mode the legal base window is 20 to 524283, so every instantaneous modulus stays between 16 and 524287.
- R5: In fractional mode an offset above +4 is treated as +4 and one below -4 as -4, and `range_err` is set.
- R6: With `pre_en` = 1 each period lasts exactly twice the modulus in input clocks, and the legal base window is 20 to 524283 in both modes.
- R7: A base below (above) the legal window of the current mode is used as the lowest (highest) legal value; `range_err` is set at that reload and stays at 1 until reset.
- R8: Changes of `mod_base`, `offset` or `frac_en` during a period do not alter that period; they take effect at the next reload.
- R9: When `test_sel` equals decimal 10, `test_tap` follows `div_pulse`; for any other code `test_tap` stays 0.
- R10: In integer mode `offset` has no effect on the period and never sets `range_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_base | input | 19 | Programmed base (average) modulus |
| offset | input | 4 | Signed per-period modulus offset from the modulator |
| frac_en | input | 1 | 1 selects fractional mode, 0 integer mode |
| pre_en | input | 1 | Enables the divide-by-two stage ahead of the counter |
| test_sel | input | 5 | Test-select code; 10 routes the divided pulse to the tap |
| div_pulse | output | 1 | One-clock pulse at each period boundary |
| test_tap | output | 1 | Test observation copy of the divided pulse |
| range_err | output | 1 | Sticky flag for a clamped base or saturated offset |

## Verification
The reload edge is where a new base, a new offset and a range violation are all taken at once, so the bench changes the base and the offset together inside one period, with a base below the fractional window and a legal negative offset. The period that follows must equal the clamped base plus the offset, and the error flag must rise at that same reload while the pulse timing stays intact. Further cases move the base or the mode a few clocks into a period and check that only the period after the next pulse changes.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

   typedef enum logic {
      DIV_INTEGER    = 1'b0,
      DIV_FRACTIONAL = 1'b1
   } div_mode_e;

   typedef struct packed {
      logic base_low;
      logic base_high;
      logic ofs_sat;
   } limit_flags_t;

endpackage

// File: rtl/fbdiv_limit.sv
module fbdiv_limit
   import fbdiv_pkg::*;
#(
   parameter int CNT_W    = 19,
   parameter int OFS_W    = 4,
   parameter int OFS_SPAN = 4,
   parameter int MIN_DIV  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   base_i,
   input  logic [OFS_W-1:0]   ofs_i,
   input  div_mode_e          mode_i,
   input  logic               pre_i,
   output logic [CNT_W-1:0]   mod_o,
   output limit_flags_t       flags_o
);

   localparam int SUM_W = CNT_W + 2;
   localparam logic [CNT_W-1:0] WIDE_LO  = CNT_W'(MIN_DIV);
   localparam logic [CNT_W-1:0] WIDE_HI  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] TIGHT_LO = CNT_W'(MIN_DIV + OFS_SPAN);
   localparam logic [CNT_W-1:0] TIGHT_HI = WIDE_HI - CNT_W'(OFS_SPAN);
   localparam logic signed [OFS_W-1:0] OFS_POS = OFS_W'(OFS_SPAN);
   localparam logic signed [OFS_W-1:0] OFS_NEG = -OFS_POS;
   localparam logic signed [SUM_W-1:0] SUM_MIN = SUM_W'(MIN_DIV);

   initial begin
      assert (OFS_SPAN < (1 << (OFS_W - 1)))
         else $error("offset span does not fit the offset width");
      assert (MIN_DIV > 2 * OFS_SPAN)
         else $error("minimum modulus too small for the offset span");
   end

   logic                     tight;
   logic [CNT_W-1:0]         lo_bound;
   logic [CNT_W-1:0]         hi_bound;
   logic [CNT_W-1:0]         base_c;
   logic signed [OFS_W-1:0]  ofs_s;
   logic signed [OFS_W-1:0]  ofs_use;
   logic signed [SUM_W-1:0]  sum;

   always_comb begin
      tight    = (mode_i == DIV_FRACTIONAL) || pre_i;
      lo_bound = tight ? TIGHT_LO : WIDE_LO;
      hi_bound = tight ? TIGHT_HI : WIDE_HI;
      flags_o.base_low  = (base_i < lo_bound);
      flags_o.base_high = (base_i > hi_bound);
      if (flags_o.base_low)       base_c = lo_bound;
      else if (flags_o.base_high) base_c = hi_bound;
      else                        base_c = base_i;
   end

   generate
      if (OFS_SPAN > 0) begin : g_frac
         always_comb begin
            ofs_s           = signed'(ofs_i);
            ofs_use         = '0;
            flags_o.ofs_sat = 1'b0;
            if (mode_i == DIV_FRACTIONAL) begin
               if (ofs_s > OFS_POS) begin
                  ofs_use         = OFS_POS;
                  flags_o.ofs_sat = 1'b1;
               end else if (ofs_s < OFS_NEG) begin
                  ofs_use         = OFS_NEG;
                  flags_o.ofs_sat = 1'b1;
               end else begin
                  ofs_use = ofs_s;
               end
            end
         end
      end else begin : g_int_only
         always_comb begin
            ofs_s           = signed'(ofs_i);
            ofs_use         = '0;
            flags_o.ofs_sat = (mode_i == DIV_FRACTIONAL) && (ofs_s != '0);
         end
      end
   endgenerate

   always_comb begin
      sum   = signed'({2'b00, base_c}) + SUM_W'(ofs_use);
      mod_o = sum[CNT_W-1:0];
   end

   // R7: the modulus handed to the counter never leaves the absolute window
   assert_mod_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sum >= SUM_MIN) && (sum[SUM_W-1 -: 2] == 2'b00));

endmodule

// File: rtl/fbdiv_prescale.sv
module fbdiv_prescale #(
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pre_i,
   output logic tick_o
);

   generate
      if (HAS_PRESCALER) begin : g_half
         logic phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n) phase_q <= 1'b0;
            else        phase_q <= ~phase_q;
         end

         assign tick_o = pre_i ? phase_q : 1'b1;

         // R6: with the halving stage on, ticks never come back to back
         assert_tick_alt_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_i && tick_o && $past(pre_i)) |=> (!tick_o || !pre_i));
      end else begin : g_direct
         logic unused_pre;
         assign unused_pre = pre_i;
         assign tick_o     = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] mod_i,
   output logic             reload_o,
   output logic             pulse_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             primed_q;
   logic             pulse_q;
   logic             at_tc;

   assign at_tc    = primed_q && (cnt_q == '0);
   assign reload_o = tick_i && (!primed_q || at_tc);
   assign pulse_o  = pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         primed_q <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         pulse_q <= tick_i && at_tc;
         if (reload_o) begin
            cnt_q    <= mod_i - 1'b1;
            primed_q <= 1'b1;
         end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R2: every output pulse lasts a single input clock
   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

   // R8: inside a period the count only steps down by one per tick
   assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && primed_q && !at_tc) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R8: the count is held between ticks
   assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && primed_q) |=> $stable(cnt_q));

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
   import fbdiv_pkg::*;
#(
   parameter int CNT_W         = 19,
   parameter int OFS_W         = 4,
   parameter int OFS_SPAN      = 4,
   parameter int MIN_DIV       = 16,
   parameter int SEL_W         = 5,
   parameter int TAP_CODE      = 10,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] mod_base,
   input  logic [OFS_W-1:0] offset,
   input  logic             frac_en,
   input  logic             pre_en,
   input  logic [SEL_W-1:0] test_sel,
   output logic             div_pulse,
   output logic             test_tap,
   output logic             range_err
);

   localparam logic [SEL_W-1:0] TAP_SEL = SEL_W'(TAP_CODE);

   initial begin
      assert (TAP_CODE < (1 << SEL_W))
         else $error("tap code does not fit the select width");
      assert (CNT_W > 5)
         else $error("counter width too small");
   end

   logic             pre_eff;
   logic             tick;
   logic             reload;
   logic [CNT_W-1:0] mod_eff;
   limit_flags_t     flags;
   logic             err_q;

   assign pre_eff = pre_en & HAS_PRESCALER;

   fbdiv_prescale #(.HAS_PRESCALER(HAS_PRESCALER)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .pre_i (pre_eff),
      .tick_o(tick)
   );

   fbdiv_limit #(
      .CNT_W   (CNT_W),
      .OFS_W   (OFS_W),
      .OFS_SPAN(OFS_SPAN),
      .MIN_DIV (MIN_DIV)
   ) u_lim (
      .clk    (clk),
      .rst_n  (rst_n),
      .base_i (mod_base),
      .ofs_i  (offset),
      .mode_i (div_mode_e'(frac_en)),
      .pre_i  (pre_eff),
      .mod_o  (mod_eff),
      .flags_o(flags)
   );

   fbdiv_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .mod_i   (mod_eff),
      .reload_o(reload),
      .pulse_o (div_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else if (reload && (flags.base_low || flags.base_high || flags.ofs_sat))
         err_q <= 1'b1;
   end

   assign range_err = err_q;
   assign test_tap  = (test_sel == TAP_SEL) & div_pulse;

   // R7: once raised, the flag holds until reset
   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |=> range_err);

   // R7: the flag only rises after a reload edge
   assert_err_at_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(range_err) |-> $past(reload));

   // R9: the tap never shows activity the divider did not produce
   assert_tap_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      test_tap |-> div_pulse);

endmodule

// File: tb/fbdiv_top_test.sv
module fbdiv_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [18:0] mod_base = 19'd16;
   logic [3:0]  offset = 4'd0;
   logic        frac_en = 1'b0;
   logic        pre_en = 1'b0;
   logic [4:0]  test_sel = 5'd0;
   logic        div_pulse;
   logic        test_tap;
   logic        range_err;

   always #5 clk = ~clk;

   fbdiv_top uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .mod_base (mod_base),
      .offset   (offset),
      .frac_en  (frac_en),
      .pre_en   (pre_en),
      .test_sel (test_sel),
      .div_pulse(div_pulse),
      .test_tap (test_tap),
      .range_err(range_err)
   );

   int    n_run = 0;
   int    n_fail = 0;
   int    exp_q[$];
   string tag_q[$];
   bit    armed = 1'b0;
   int    skip = 0;
   int    gap = 0;
   bit    prev_pulse = 1'b0;
   bit    exp_err = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lo_of(input bit frac, input bit pre);
      return (frac || pre) ? 20 : 16;
   endfunction

   function automatic int hi_of(input bit frac, input bit pre);
      return (frac || pre) ? 524283 : 524287;
   endfunction

   function automatic int exp_period(input int base, input bit frac, input bit pre, input int ofs);
      int m;
      int o;
      m = base;
      if (m < lo_of(frac, pre)) m = lo_of(frac, pre);
      if (m > hi_of(frac, pre)) m = hi_of(frac, pre);
      o = 0;
      if (frac) o = (ofs > 4) ? 4 : (ofs < -4) ? -4 : ofs;
      return (m + o) * (pre ? 2 : 1);
   endfunction

   function automatic bit err_of(input int base, input bit frac, input bit pre, input int ofs);
      return (base < lo_of(frac, pre)) || (base > hi_of(frac, pre)) ||
             (frac && (ofs > 4 || ofs < -4));
   endfunction

   task automatic apply(input int base, input bit frac, input int ofs, input string req);
      mod_base = 19'(base);
      frac_en  = frac;
      offset   = 4'(ofs);
      exp_q.push_back(exp_period(base, frac, pre_en, ofs));
      tag_q.push_back(req);
      if (err_of(base, frac, pre_en, ofs)) exp_err = 1'b1;
   endtask

   task automatic start_seg(input int base, input bit frac, input bit pre,
                            input int sel, input int ofs, input string req);
      @(posedge clk); #1;
      rst_n    = 1'b0;
      pre_en   = pre;
      test_sel = 5'(sel);
      exp_err  = 1'b0;
      exp_q.delete();
      tag_q.delete();
      apply(base, frac, ofs, req);
      skip  = 1;
      armed = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic step(input int base, input bit frac, input int ofs,
                       input int dly, input string req);
      do begin
         @(posedge clk); #1;
      end while (!div_pulse);
      repeat (dly) @(posedge clk);
      #1;
      apply(base, frac, ofs, req);
   endtask

   task automatic finish_seg(input string req);
      while (exp_q.size() != 0) begin
         @(posedge clk); #1;
      end
      armed = 1'b0;
      check(req, range_err, exp_err);
   endtask

   task automatic flag_only(input int base, input bit frac, input bit pre, input string req);
      @(posedge clk); #1;
      armed    = 1'b0;
      rst_n    = 1'b0;
      pre_en   = pre;
      frac_en  = frac;
      mod_base = 19'(base);
      offset   = 4'd0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      check(req, range_err, err_of(base, frac, pre, 0));
   endtask

   // monitor: measures pulse spacing and compares against the scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         gap        <= 0;
         prev_pulse <= 1'b0;
      end else begin
         prev_pulse <= div_pulse;
         if (div_pulse && prev_pulse) check("R2 pulse width", 2, 1);
         if (div_pulse) begin
            check("R9 tap", test_tap, (test_sel == 5'd10));
            gap <= 0;
            if (armed) begin
               if (skip > 0) skip <= skip - 1;
               else if (exp_q.size() != 0) check(tag_q.pop_front(), gap + 1, exp_q.pop_front());
               else check("R8 unexpected pulse", gap + 1, 0);
            end
         end else begin
            gap <= gap + 1;
            if (test_tap) check("R9 tap idle", 1, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 div_pulse", div_pulse, 0);
      check("R1 test_tap", test_tap, 0);
      check("R1 range_err", range_err, 0);

      // R2 and R10: integer mode ignores a large offset
      start_seg(16, 0, 0, 10, 7, "R10 int ignores offset");
      step(16, 0, -3, 0, "R2 int period 16");
      step(16, 0, 5, 0, "R10 int ignores offset");
      step(16, 0, -8, 0, "R2 int period 16");
      finish_seg("R10 no flag from offset");

      // R8: base and mode moved inside a period
      start_seg(37, 0, 0, 3, 0, "R2 int period 37");
      step(37, 0, 0, 0, "R2 int period 37");
      step(23, 0, 0, 5, "R8 base change mid-period");
      step(23, 0, 0, 0, "R8 base change settles");
      step(40, 1, -2, 7, "R8 mode change mid-period");
      step(40, 1, -2, 0, "R3 frac period 38");
      finish_seg("R8 no flag");

      // R7: base below the integer window
      start_seg(10, 0, 0, 10, 0, "R7 low clamp int");
      step(2, 0, 0, 0, "R7 low clamp int");
      finish_seg("R7 sticky flag");

      // R3: offset sequence in fractional mode
      start_seg(30, 1, 0, 10, -4, "R3 offset -4");
      step(30, 1, 4, 0, "R3 offset +4");
      step(30, 1, 0, 0, "R3 offset 0");
      step(30, 1, -1, 0, "R3 offset -1");
      step(30, 1, 3, 0, "R3 offset +3");
      step(30, 1, 2, 0, "R3 offset +2");
      step(30, 1, -4, 0, "R3 offset -4");
      finish_seg("R3 no flag");

      // R4: fractional window edge
      start_seg(20, 1, 0, 10, -4, "R4 frac min base");
      step(20, 1, -4, 0, "R4 frac min base");
      step(19, 1, 0, 0, "R4 frac below window");
      finish_seg("R4 flag");

      // R5: offset saturation
      start_seg(25, 1, 0, 10, 7, "R5 offset sat high");
      step(25, 1, -8, 0, "R5 offset sat low");
      finish_seg("R5 flag");

      // R6: prescaler in integer mode
      start_seg(20, 0, 1, 10, 0, "R6 pre period 40");
      step(20, 0, 0, 0, "R6 pre period 40");
      step(16, 0, 0, 0, "R6 pre low clamp");
      finish_seg("R6 flag");

      // R6: prescaler with fractional offsets
      start_seg(25, 1, 1, 12, 3, "R6 pre frac +3");
      step(25, 1, -4, 0, "R6 pre frac -4");
      step(21, 1, -4, 0, "R6 pre frac 17");
      step(22, 1, 2, 0, "R6 pre frac 24");
      finish_seg("R6 no flag");

      // base and offset change together with a clamp at the same reload
      start_seg(50, 1, 0, 10, 0, "R3 frac period 50");
      step(18, 1, -3, 3, "R7 clamp with offset");
      step(18, 1, -3, 0, "R7 clamp with offset");
      finish_seg("R7 flag with offset");

      // upper window edges
      flag_only(524287, 0, 0, "R2 int max legal");
      flag_only(524287, 1, 0, "R7 frac high clamp");
      flag_only(524284, 0, 1, "R6 pre high clamp");
      flag_only(524283, 1, 0, "R4 frac max legal");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule